// File: doc/BRIEF.md
# Receive Packet Ready Gating

This block sits between a demodulator and a host's serial receive port. It decides when received payload bits may go out to the host. It raises a ready flag that brackets the whole serial transfer. While the flag is high, each valid payload bit is passed to a serial data line together with a one-cycle clock enable. The flag stays low while the receiver is still acquiring the preamble. It also stays low while the receiver is in standby.

A transfer opens on the rising edge of a synchronization-done input. The flag then falls on the first of three events:

- the upstream source reports that no data remains,
- a programmed number of payload bits has been delivered,
- the link is reported lost.

Disabling the receiver also closes the transfer. After the flag falls, a new transfer needs a fresh synchronization edge. The synchronization input must therefore go low, as it does when the receiver goes back to acquisition, and then rise again.

Top module: `rx_ready_gate`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rdy` is low after that edge and `sd_ce` and `sd_bit` are low.
- R2: `rdy` rises one cycle after a clock edge that sees `sync_done` high when it was low at the previous edge, with `rx_en` high and `link_lost` low. While `sync_done` has not risen (preamble acquisition), `rdy` stays low.
- R3: While `rx_en` is low no transfer opens. If `rx_en` goes low during a transfer, `sd_ce` is low in that cycle and `rdy` is low from the next cycle.
- R4: `sd_ce` is high exactly in cycles where `rdy`, `pay_vld` and `rx_en` are high and `link_lost` is low. In those cycles `sd_bit` equals `pay_bit`; in all other cycles it is 0.
- R5: A cycle with `data_end` high during a transfer still delivers that cycle's valid bit, and `rdy` is low from the next cycle.
- R6: With a nonzero length N taken from `len_cfg` at the opening edge, `rdy` falls in the cycle after the N-th delivered bit. Later changes to `len_cfg` do not affect the open transfer.
- R7: A length of zero sets no limit: the transfer continues for any number of bits.
- R8: When `link_lost` is high, that cycle delivers no bit and `rdy` is low from the next cycle.
- R9: After `rdy` falls, holding `sync_done` high does not reopen the transfer. Only a new low-to-high edge does.
- R10: The delivered-bit count restarts from zero at each opening edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_en | input | 1 | Receiver enable; low means standby |
| sync_done | input | 1 | Preamble synchronization achieved (level, edge opens a transfer) |
| pay_bit | input | 1 | Received payload bit |
| pay_vld | input | 1 | Payload bit valid strobe |
| data_end | input | 1 | Upstream has no more received data |
| link_lost | input | 1 | Link interrupted |
| len_cfg | input | LEN_W | Transfer length in bits, 0 = unlimited |
| rdy | output | 1 | Transfer envelope to the host, active high |
| sd_bit | output | 1 | Serial receive data to the host |
| sd_ce | output | 1 | Clock enable qualifying `sd_bit` |

## Verification
The in-line properties check the rules that must hold on every cycle:

- the flag opens only after a qualifying synchronization edge;
- the flag falls after the end-of-data indication, after link loss, and in standby;
- the data line is quiet without its enable;
- the bit count never reaches the latched length while the flag is high.

Only the directed scenarios can show behaviour that spans a whole transfer:

- the exact bit at which a length-limited transfer ends;
- a transfer with length zero that never ends on count;
- a length latched at the opening edge, so later changes to `len_cfg` have no effect;
- the count restarting from zero for a second packet;
- no reopening while `sync_done` is held high.

// File: rtl/rx_ready_gate.sv
module rx_ready_gate #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             sync_done,
  input  logic             pay_bit,
  input  logic             pay_vld,
  input  logic             data_end,
  input  logic             link_lost,
  input  logic [LEN_W-1:0] len_cfg,
  output logic             rdy,
  output logic             sd_bit,
  output logic             sd_ce
);

  logic             sync_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt;
  logic             open_evt;
  logic             last_bit;
  logic             close_evt;

  assign open_evt  = sync_done & ~sync_q & rx_en & ~link_lost & ~rdy;
  assign sd_ce     = rdy & pay_vld & rx_en & ~link_lost;
  assign sd_bit    = sd_ce & pay_bit;
  assign last_bit  = (len_q != '0) & sd_ce & (cnt == len_q - 1'b1);
  assign close_evt = rdy & (data_end | link_lost | ~rx_en | last_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      rdy    <= 1'b0;
      cnt    <= '0;
      len_q  <= '0;
    end else begin
      sync_q <= sync_done;
      if (open_evt) begin
        rdy   <= 1'b1;
        cnt   <= '0;
        len_q <= len_cfg;
      end else begin
        if (close_evt) rdy <= 1'b0;
        if (sd_ce)     cnt <= cnt + 1'b1;
      end
    end
  end

  p_reset_low_r1: assert property (@(posedge clk) !rst_n |=> !rdy);

  p_open_on_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> $past(sync_done && rx_en && !link_lost));

  p_standby_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rdy);

  p_quiet_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_ce |-> !sd_bit);

  p_end_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && data_end) |=> !rdy);

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && len_q != '0) |-> cnt < len_q);

  p_link_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    link_lost |-> !sd_ce);

  p_link_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && link_lost) |=> !rdy);

  p_no_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && $past(sync_done) && sync_done) |=> !rdy);

endmodule

// File: tb/rx_ready_gate_tb.sv
module rx_ready_gate_tb;
  localparam int LW = 12;
  logic clk = 0, rst_n = 0, rx_en = 0, sync_done = 0, pay_bit = 0, pay_vld = 0;
  logic data_end = 0, link_lost = 0;
  logic [LW-1:0] len_cfg = '0;
  logic rdy, sd_bit, sd_ce;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_ready_gate #(.LEN_W(LW)) u_dut (.clk(clk), .rst_n(rst_n), .rx_en(rx_en),
    .sync_done(sync_done), .pay_bit(pay_bit), .pay_vld(pay_vld), .data_end(data_end),
    .link_lost(link_lost), .len_cfg(len_cfg), .rdy(rdy), .sd_bit(sd_bit), .sd_ce(sd_ce));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic open_pkt(input logic [LW-1:0] len);
    len_cfg = len; sync_done = 1; tick(); sync_done = 0;
  endtask

  task automatic send(input logic b, output logic ce, output logic bo);
    pay_vld = 1; pay_bit = b; #1; ce = sd_ce; bo = sd_bit;
    tick(); pay_vld = 0; pay_bit = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; rx_en = 1; tick(); tick();
    chk("R1 rdy in reset", rdy, 0);
    pay_vld = 1; pay_bit = 1; #1;
    chk("R1 sd_ce in reset", sd_ce, 0);
    chk("R1 sd_bit in reset", sd_bit, 0);
    pay_vld = 0; pay_bit = 0;
    rst_n = 1; tick();
  endtask

  task automatic t_preamble();
    repeat (3) tick();
    chk("R2 rdy low during acquisition", rdy, 0);
    open_pkt(0);
    chk("R2 rdy after sync edge", rdy, 1);
    link_lost = 1; tick(); link_lost = 0; tick();
  endtask

  task automatic t_stream_data_end();
    logic ce, bo;
    logic [7:0] pat = 8'b1011_0010;
    open_pkt(0);
    for (int i = 0; i < 8; i++) begin
      send(pat[i], ce, bo);
      chk("R4 sd_ce on valid bit", ce, 1);
      chk("R4 sd_bit follows payload", bo, pat[i]);
    end
    pay_bit = 1; #1;
    chk("R4 sd_bit zero without valid", sd_bit, 0);
    pay_bit = 0;
    data_end = 1;
    send(1, ce, bo);
    data_end = 0;
    chk("R5 bit delivered on end cycle", ce, 1);
    chk("R5 rdy low after end", rdy, 0);
    tick();
  endtask

  task automatic t_length();
    logic ce, bo;
    open_pkt(3);
    len_cfg = 9;
    send(1, ce, bo); send(0, ce, bo);
    chk("R6 rdy held before limit", rdy, 1);
    send(1, ce, bo);
    chk("R6 last counted bit delivered", ce, 1);
    chk("R6 rdy low after limit, latched length", rdy, 0);
    send(1, ce, bo);
    chk("R6 no delivery after limit", ce, 0);
    open_pkt(2);
    send(1, ce, bo);
    chk("R10 count restarted", rdy, 1);
    send(0, ce, bo);
    chk("R10 second packet ends at its length", rdy, 0);
  endtask

  task automatic t_unlimited();
    logic ce, bo;
    int ok = 1;
    open_pkt(0);
    for (int i = 0; i < 5000; i++) begin
      send(i[0], ce, bo);
      if (!ce || !rdy) ok = 0;
    end
    chk("R7 zero length unlimited", ok, 1);
    data_end = 1; tick(); data_end = 0; tick();
  endtask

  task automatic t_link();
    logic ce, bo;
    open_pkt(0);
    send(1, ce, bo);
    link_lost = 1;
    send(1, ce, bo);
    link_lost = 0;
    chk("R8 no bit on link loss", ce, 0);
    chk("R8 rdy low after link loss", rdy, 0);
  endtask

  task automatic t_standby();
    logic ce, bo;
    rx_en = 0; tick();
    open_pkt(0);
    chk("R3 no open in standby", rdy, 0);
    rx_en = 1; tick();
    open_pkt(0);
    chk("R3 open when enabled", rdy, 1);
    rx_en = 0;
    send(1, ce, bo);
    chk("R3 no bit when disabled", ce, 0);
    chk("R3 rdy low after disable", rdy, 0);
    rx_en = 1; tick();
  endtask

  task automatic t_no_rearm();
    open_pkt(0);
    sync_done = 1;
    data_end = 1; tick(); data_end = 0;
    chk("R9 closed by end", rdy, 0);
    repeat (4) tick();
    chk("R9 held sync does not reopen", rdy, 0);
    sync_done = 0; tick();
    open_pkt(0);
    chk("R9 fresh edge reopens", rdy, 1);
    data_end = 1; tick(); data_end = 0; tick();
  endtask

  initial begin
    t_reset();
    t_preamble();
    t_stream_data_end();
    t_length();
    t_unlimited();
    t_link();
    t_standby();
    t_no_rearm();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule